// File: doc/BRIEF.md
# Run-Length Scanline Display Layer

This layer produces one palette index per pixel clock from a list of (colour, run length) pairs rather than from a bitmap. Each pair paints a horizontal run of identical pixels. A scanline is therefore a variable-length list of runs. A run ends either when its length counts out or when the line ends on the falling edge of the active-low horizontal sync. Both events step the read pointer to the next pair. Vertical sync or a low display enable sends the pointer back to pair 0 and forces the output to index 0.

The pair store holds two banks. Software fills one bank through the write port while the other is shown, and then selects the new bank. The colour byte and the length byte of a pair sit in separate RAMs, so the layer reads both in one cycle. In the write address space they alternate, so a linear byte stream fills the pairs in order. At the full-size setting (`SEG_AW` = 13) each bank holds 8K pairs and spans a 16K byte window. At a 6.048 MHz pixel clock with 384-pixel lines and 224 visible lines, that allows about 36 runs per line.

The write port is valid/ready, but `wr_ready` is tied high: every beat offered with `wr_valid` is taken in that cycle, and the port never applies back-pressure. A write may target the bank on display. Nothing protects against this, and a pair that has not yet been read shows its new contents.

Top module: `rlvec_layer`

## Requirements
- R1: While reset is asserted and after it is released, `pix_idx` is 0 and `wr_ready` is 1. Every `wr_valid` beat is accepted in the cycle it is offered.
- R2: A clock edge that samples `vsync_n` low resets the read pointer to pair 0 and clears the colour, so `pix_idx` is 0 in the next cycle. Display resumes at pair 0.
- R3: A clock edge that samples `den` low behaves exactly as R2, including the restart at pair 0 with a full-length first run.
- R4: On the first clock edge with both `vsync_n` and `den` high, pair 0 is read. Its colour appears on `pix_idx` from the next cycle.
- R5: A pair whose length byte is L holds its colour for exactly L pixel clocks. L = 0 means 256.
- R6: When a run expires, the next pair's colour appears in the very next cycle, with no gap, and its length starts counting.
- R7: A clock edge that sees a falling edge of `hsync_n` ends the current run at once and loads the next pair, with its full length. A rising edge of `hsync_n` has no effect. If the falling edge coincides with a run expiry, the pointer advances by one pair only.
- R8: Write address decode: the most significant bits select the bank. The lowest bit selects the byte within the pair: 0 for the colour byte, 1 for the length byte. The bits between select the pair index. The byte at address 2i belongs to pair i, and the byte at 2i+1 is its length.
- R9: `bank_sel` is sampled only on clock edges during blanking (R2/R3 conditions). A change while the display is active has no effect until the next blanking.
- R10: A write to the displayed bank is visible when the layer later reads that pair, within the same line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_n | input | 1 | Active-low vertical sync; low blanks and restarts the list |
| hsync_n | input | 1 | Active-low horizontal sync; falling edge ends the line |
| den | input | 1 | Display enable; low acts like vertical sync |
| bank_sel | input | BANK_W | Bank to display, sampled during blanking |
| wr_valid | input | 1 | Write beat offered |
| wr_ready | output | 1 | Write beat accepted (always high) |
| wr_addr | input | WA_W | Byte address: bank, pair index, colour/length select |
| wr_data | input | DATA_W | Byte to store |
| pix_idx | output | DATA_W | Palette index of the current pixel |

## Verification
The bench builds the layer with `SEG_AW` = 4, which gives 16 pairs per bank and a 6-bit write address. Filling a bank then takes a handful of beats, so the bench has cycles left for long runs. The length and colour widths stay at 8 bits, so the 256-pixel run encoded by a zero length is covered. The bench walks a full pair list cycle by cycle. It also hits the cases where the line ends mid-run, where the line ends in the same cycle a run expires, where the bank changes during the active display, and where a pair is rewritten just before it is read.

// File: rtl/rlvec_pkg.sv
package rlvec_pkg;

  // Lowest write-address bit: which byte of a pair is addressed.
  typedef enum logic {
    SEL_COLOUR = 1'b0,
    SEL_LENGTH = 1'b1
  } byte_sel_e;

endpackage

// File: rtl/rlvec_seg_store.sv
module rlvec_seg_store
  import rlvec_pkg::*;
#(
  parameter int BANKS  = 2,
  parameter int SEG_AW = 9,
  parameter int DATA_W = 8,
  localparam int BANK_W = $clog2(BANKS),
  localparam int DEPTH  = 1 << SEG_AW
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_bank,
  input  byte_sel_e         wr_sel,
  input  logic [SEG_AW-1:0] wr_seg,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [SEG_AW-1:0] rd_seg,
  output logic [DATA_W-1:0] rd_col,
  output logic [DATA_W-1:0] rd_len
);

  logic [DATA_W-1:0] col_rd [BANKS];
  logic [DATA_W-1:0] len_rd [BANKS];

  // One colour RAM and one length RAM per bank, so a pair reads in one cycle.
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] col_mem [DEPTH];
    logic [DATA_W-1:0] len_mem [DEPTH];
    logic              hit;

    assign hit = wr_en && (wr_bank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (hit && (wr_sel == SEL_COLOUR)) begin
        col_mem[wr_seg] <= wr_data;
      end
      if (hit && (wr_sel == SEL_LENGTH)) begin
        len_mem[wr_seg] <= wr_data;
      end
    end

    assign col_rd[b] = col_mem[rd_seg];
    assign len_rd[b] = len_mem[rd_seg];
  end

  assign rd_col = col_rd[rd_bank];
  assign rd_len = len_rd[rd_bank];

endmodule

// File: rtl/rlvec_run_cnt.sv
module rlvec_run_cnt #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             step,
  input  logic [LEN_W-1:0] len,
  output logic             last
);

  // Loaded with the two's complement of the length and counted up.
  // The all-ones value marks the final pixel of the run, and 0 wraps to 256.
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= LEN_W'(0) - len;
    end else if (step) begin
      cnt_q <= cnt_q + LEN_W'(1);
    end
  end

  assign last = &cnt_q;

  AST_ONE_PIXEL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load && (len == LEN_W'(1))) |=> last) else $error("one-pixel run not last"); // R5

  AST_LONG_RUN_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load && (len != LEN_W'(1))) |=> !last) else $error("long run ended early"); // R5

endmodule

// File: rtl/rlvec_scan_ctrl.sv
module rlvec_scan_ctrl #(
  parameter int BANKS  = 2,
  parameter int SEG_AW = 9,
  parameter int DATA_W = 8,
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_n,
  input  logic              hsync_n,
  input  logic              den,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [DATA_W-1:0] rd_col,
  input  logic              run_last,
  output logic [SEG_AW-1:0] look_addr,
  output logic [BANK_W-1:0] disp_bank,
  output logic              cnt_clr,
  output logic              cnt_load,
  output logic              cnt_step,
  output logic [DATA_W-1:0] colour
);

  logic              blank;
  logic              hfall;
  logic              advance;
  logic              hsync_q;
  logic              loaded_q;
  logic [SEG_AW-1:0] addr_q;
  logic [BANK_W-1:0] bank_q;
  logic [DATA_W-1:0] col_q;

  assign blank   = !vsync_n || !den;
  assign hfall   = hsync_q && !hsync_n;
  // A run expiry and a line end in the same cycle still step the pointer only once.
  assign advance = loaded_q && (run_last || hfall);

  assign look_addr = advance ? (addr_q + SEG_AW'(1)) : addr_q;
  assign cnt_clr   = blank;
  assign cnt_load  = !blank && (!loaded_q || advance);
  assign cnt_step  = !blank && loaded_q && !advance;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync_q  <= 1'b1;
      loaded_q <= 1'b0;
      addr_q   <= '0;
      bank_q   <= '0;
      col_q    <= '0;
    end else begin
      hsync_q <= hsync_n;
      if (blank) begin
        loaded_q <= 1'b0;
        addr_q   <= '0;
        col_q    <= '0;
        bank_q   <= bank_sel;
      end else if (cnt_load) begin
        loaded_q <= 1'b1;
        addr_q   <= look_addr;
        col_q    <= rd_col;
      end
    end
  end

  assign disp_bank = bank_q;
  assign colour    = col_q;

  AST_BLANK_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> (addr_q == '0) && !loaded_q) else $error("blanking did not rewind"); // R2

  AST_STEP_ONE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank && loaded_q && (run_last || hfall)) |=> (addr_q == $past(addr_q) + SEG_AW'(1)))
    else $error("pointer did not step by one pair"); // R7

  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank && loaded_q && !run_last && !hfall) |=> ($stable(addr_q) && $stable(col_q)))
    else $error("run changed before its end"); // R5

  AST_BANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !blank |=> $stable(bank_q)) else $error("bank changed while active"); // R9

endmodule

// File: rtl/rlvec_layer.sv
module rlvec_layer
  import rlvec_pkg::*;
#(
  parameter int BANKS  = 2,
  parameter int SEG_AW = 9,
  parameter int DATA_W = 8,
  localparam int BANK_W = $clog2(BANKS),
  localparam int WA_W   = BANK_W + SEG_AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_n,
  input  logic              hsync_n,
  input  logic              den,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WA_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] pix_idx
);

  logic [SEG_AW-1:0] look_addr;
  logic [BANK_W-1:0] disp_bank;
  logic [DATA_W-1:0] rd_col;
  logic [DATA_W-1:0] rd_len;
  logic              cnt_clr;
  logic              cnt_load;
  logic              cnt_step;
  logic              run_last;
  byte_sel_e         wr_sel;

  // The store takes one beat per cycle, so the port never pushes back.
  assign wr_ready = 1'b1;
  assign wr_sel   = byte_sel_e'(wr_addr[0]);

  rlvec_seg_store #(
    .BANKS  (BANKS),
    .SEG_AW (SEG_AW),
    .DATA_W (DATA_W)
  ) u_store (
    .clk     (clk),
    .wr_en   (wr_valid),
    .wr_bank (wr_addr[WA_W-1 -: BANK_W]),
    .wr_sel  (wr_sel),
    .wr_seg  (wr_addr[SEG_AW:1]),
    .wr_data (wr_data),
    .rd_bank (disp_bank),
    .rd_seg  (look_addr),
    .rd_col  (rd_col),
    .rd_len  (rd_len)
  );

  rlvec_scan_ctrl #(
    .BANKS  (BANKS),
    .SEG_AW (SEG_AW),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .vsync_n   (vsync_n),
    .hsync_n   (hsync_n),
    .den       (den),
    .bank_sel  (bank_sel),
    .rd_col    (rd_col),
    .run_last  (run_last),
    .look_addr (look_addr),
    .disp_bank (disp_bank),
    .cnt_clr   (cnt_clr),
    .cnt_load  (cnt_load),
    .cnt_step  (cnt_step),
    .colour    (pix_idx)
  );

  rlvec_run_cnt #(
    .LEN_W (DATA_W)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .load  (cnt_load),
    .step  (cnt_step),
    .len   (rd_len),
    .last  (run_last)
  );

  AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!vsync_n || !den) |=> (pix_idx == '0)) else $error("pixel not cleared in blanking"); // R2 R3

  AST_FIRST_LOAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!vsync_n || !den) && vsync_n && den) |-> cnt_load) else $error("first pair not loaded"); // R4

endmodule

// File: tb/test_rlvec_layer.sv
module test_rlvec_layer;

  localparam int SEG_AW = 4;
  localparam int DATA_W = 8;
  localparam int BANK_W = 1;
  localparam int WA_W   = BANK_W + SEG_AW + 1;

  // Bank 0 pair list: colour in the high byte, length in the low byte (0 = 256).
  localparam logic [15:0] LIST0 [7] = '{16'h1103, 16'h2201, 16'h3305, 16'h4402,
                                        16'h5500, 16'h6604, 16'h7702};
  localparam logic [15:0] LIST1 [4] = '{16'hA105, 16'hB203, 16'hC302, 16'hD406};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              vsync_n = 1'b0;
  logic              hsync_n = 1'b1;
  logic              den = 1'b0;
  logic [BANK_W-1:0] bank_sel = '0;
  logic              wr_valid = 1'b0;
  logic              wr_ready;
  logic [WA_W-1:0]   wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] pix_idx;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rlvec_layer #(
    .BANKS  (2),
    .SEG_AW (SEG_AW),
    .DATA_W (DATA_W)
  ) i_rlvec_layer (
    .clk      (clk),
    .rst_n    (rst_n),
    .vsync_n  (vsync_n),
    .hsync_n  (hsync_n),
    .den      (den),
    .bank_sel (bank_sel),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .pix_idx  (pix_idx)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (pix_idx !== exp) begin
      n_err++;
      $display("FAIL %s: pix_idx=%h expected %h", req, pix_idx, exp);
    end
  endtask

  // R8: address = {bank, pair index, byte select}
  task automatic put(input logic b, input logic [SEG_AW-1:0] seg, input logic sel,
                     input logic [DATA_W-1:0] d);
    tick();
    wr_valid = 1'b1;
    wr_addr  = {b, seg, sel};
    wr_data  = d;
    tick();
    wr_valid = 1'b0;
  endtask

  task automatic blank_then_go();
    tick();
    vsync_n = 1'b0;
    tick();
    tick();
    vsync_n = 1'b1;
  endtask

  initial begin
    repeat (3) tick();
    // R1: reset state
    chk("R1 reset pixel", 8'h00);
    n_chk++;
    if (wr_ready !== 1'b1) begin
      n_err++;
      $display("FAIL R1: wr_ready=%b expected 1", wr_ready);
    end
    rst_n = 1'b1;
    tick();
    chk("R1 after reset", 8'h00);

    // R8: fill both banks with colour at even, length at odd addresses
    for (int i = 0; i < 7; i++) begin
      put(1'b0, SEG_AW'(i), 1'b0, LIST0[i][15:8]);
      put(1'b0, SEG_AW'(i), 1'b1, LIST0[i][7:0]);
    end
    for (int i = 0; i < 4; i++) begin
      put(1'b1, SEG_AW'(i), 1'b0, LIST1[i][15:8]);
      put(1'b1, SEG_AW'(i), 1'b1, LIST1[i][7:0]);
    end

    // R4 R5 R6 R8: walk the bank 0 list pixel by pixel
    tick();
    vsync_n = 1'b1;
    den     = 1'b1;
    for (int i = 0; i < 7; i++) begin
      int run;
      run = (LIST0[i][7:0] == 8'h00) ? 256 : int'(LIST0[i][7:0]);
      for (int k = 0; k < run; k++) begin
        tick();
        chk("R4 R5 R6 R8 list walk", LIST0[i][15:8]);
      end
    end

    // R2: vertical sync clears and restarts at pair 0
    vsync_n = 1'b0;
    tick();
    chk("R2 vsync clears", 8'h00);
    tick();
    vsync_n = 1'b1;
    tick();
    chk("R2 restart pair 0", 8'h11);

    // R3: display enable low acts like vsync, mid-run
    tick();
    chk("R3 before", 8'h11);
    den = 1'b0;
    tick();
    chk("R3 den clears", 8'h00);
    den = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R3 full first run", 8'h11);
    end
    tick();
    chk("R3 next pair", 8'h22);

    // R9: bank change during active display is ignored until blanking
    tick();
    vsync_n = 1'b0;
    tick();
    tick();
    vsync_n  = 1'b1;
    bank_sel = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R9 old bank kept", 8'h11);
    end
    tick();
    chk("R9 old bank next", 8'h22);

    // R9 + R7: after blanking bank 1 shows; line end cuts a run short
    blank_then_go();
    tick();
    chk("R9 new bank", 8'hA1);
    tick();
    chk("R7 before line end", 8'hA1);
    hsync_n = 1'b0;
    tick();
    chk("R7 line end advances", 8'hB2);
    tick();
    chk("R7 full next run", 8'hB2);
    hsync_n = 1'b1;
    tick();
    chk("R7 rising edge ignored", 8'hB2);
    tick();
    chk("R7 after next run", 8'hC3);

    // R7: line end in the same cycle as an expiry steps once
    blank_then_go();
    for (int k = 0; k < 5; k++) begin
      tick();
      chk("R5 bank1 run", 8'hA1);
    end
    hsync_n = 1'b0;
    tick();
    chk("R7 coincident single step", 8'hB2);
    hsync_n = 1'b1;
    tick();
    chk("R7 coincident run", 8'hB2);
    tick();
    chk("R7 coincident run end", 8'hB2);
    tick();
    chk("R7 coincident following", 8'hC3);

    // R10: rewrite displayed pair 1 colour while pair 0 is showing
    blank_then_go();
    tick();
    chk("R10 pair 0", 8'hA1);
    wr_valid = 1'b1;
    wr_addr  = {1'b1, SEG_AW'(1), 1'b0};
    wr_data  = 8'hE5;
    tick();
    wr_valid = 1'b0;
    chk("R10 pair 0 during write", 8'hA1);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R10 pair 0 tail", 8'hA1);
    end
    tick();
    chk("R10 R8 new colour shown", 8'hE5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule